// File: doc/BRIEF.md
# Frame-Indexed Reverse Translation Search

This block holds a single translation table shared by every process in the system. The table has one slot per physical frame. Each slot records which process owns that frame and which virtual page of that process lives there, plus a flag that says whether the slot is in use. The frame number itself is not stored: it is the position of the slot in the table.

A translation request carries a process tag, a virtual page number and a byte offset. The block walks the table one slot per clock, starting at slot 0. It stops at the first in-use slot whose process tag and page number both equal the request's. The physical address it returns is that slot's index with the request offset appended. If no slot matches, it raises a fault. A separate write port lets software load or clear the slot of any frame at any time, including while a walk is in progress.

Top module: `ipt_lookup`

## Requirements
- R1: After reset `busy`, `done` and `fault` are low, `pa_out` is zero and every slot is unused, so any lookup faults.
- R2: On a match in slot k, `done` goes high for one cycle with `fault` low and `pa_out` equal to k in bits [15:11] and the request offset in bits [10:0].
- R3: A slot matches only when both its process tag and its page number equal the request's. Agreement on one field alone gives a fault.
- R4: A slot whose use flag is clear never matches, even when its tag and page agree with the request.
- R5: The walk starts at slot 0 and advances one slot per cycle. A match in slot k raises `done` k+1 cycles after the edge that accepts the request, and when several slots match, the lowest index wins.
- R6: When no slot matches, `done` and `fault` rise together 32 cycles after acceptance, only after slot 31 is examined, and `pa_out` reads zero.
- R7: `busy` is high from the accepting edge until the cycle in which `done` is high, where it is low. A request presented while `busy` is high is ignored and does not change the walk in progress or its result.
- R8: A write (`wr_en` high) stores the tag, page and use flag into slot `wr_idx` at the clock edge. Every comparison in a later cycle sees the new contents, including a slot not yet reached by the walk in progress. A write with the use flag clear removes a mapping.
- R9: `done` is a single-cycle pulse and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_pid | input | 8 | Process tag of the request |
| req_vpn | input | 11 | Virtual page number of the request |
| req_off | input | 11 | Byte offset within the page |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Valid with `done`: no slot matched |
| pa_out | output | 16 | Physical address {slot index, offset} |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 5 | Slot (frame) to write |
| wr_pid | input | 8 | Owning process tag to store |
| wr_vpn | input | 11 | Page number to store |
| wr_valid | input | 1 | Use flag to store |

## Verification
The lookup is exercised with matches in the first slot, a middle slot and the last slot. Comparing these separates a correct index-to-frame mapping from an off-by-one walk and confirms the k+1 latency. Near misses that share only the process tag or only the page number, and a slot with agreeing fields but a clear use flag, distinguish a full two-field comparison that respects the use flag from a partial one. Duplicate mappings test first-match priority. A request pushed in during a walk, and a slot written ahead of the walk pointer, show whether input is correctly ignored and whether writes become visible to the comparison in time.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  // Physical address = slot index placed above the page offset.
  function automatic logic [31:0] join_pa(input logic [31:0] slot,
                                          input logic [31:0] offset,
                                          input int unsigned off_w);
    return (slot << off_w) | offset;
  endfunction

  // A slot hits when it is in use and both tag fields agree.
  function automatic logic slot_hit(input logic used,
                                    input logic tag_eq,
                                    input logic page_eq);
    return used & tag_eq & page_eq;
  endfunction

endpackage

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int FRAMES = 32,
  parameter int PID_W  = 8,
  parameter int VPN_W  = 11,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_used,
  output logic [PID_W-1:0] rd_pid,
  output logic [VPN_W-1:0] rd_vpn
);

  logic             used_q [FRAMES];
  logic [PID_W-1:0] pid_q  [FRAMES];
  logic [VPN_W-1:0] vpn_q  [FRAMES];

  for (genvar g = 0; g < FRAMES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        used_q[g] <= 1'b0;
        pid_q[g]  <= '0;
        vpn_q[g]  <= '0;
      end else if (sel) begin
        used_q[g] <= wr_valid;
        pid_q[g]  <= wr_pid;
        vpn_q[g]  <= wr_vpn;
      end
    end
  end

  assign rd_used = used_q[rd_idx];
  assign rd_pid  = pid_q[rd_idx];
  assign rd_vpn  = vpn_q[rd_idx];

endmodule

// File: rtl/ipt_scan.sv
module ipt_scan #(
  parameter int FRAMES = 32,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hit,
  output logic             busy,
  output logic [IDX_W-1:0] scan_idx,
  output logic             last,
  output logic             finish
);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  assign busy     = busy_q;
  assign scan_idx = idx_q;
  assign last     = (idx_q == IDX_W'(FRAMES - 1));
  assign finish   = busy_q && (hit || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (finish) busy_q <= 1'b0;
      else        idx_q  <= idx_q + IDX_W'(1);
    end
  end

endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int FRAMES = 32,
  parameter int PID_W  = 8,
  parameter int VPN_W  = 11,
  parameter int OFF_W  = 11,
  localparam int IDX_W = $clog2(FRAMES),
  localparam int PA_W  = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [OFF_W-1:0] req_off,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  pa_out,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_valid
);

  // Named internal events, visible to the bound checker.
  logic             start;
  logic             hit;
  logic             last;
  logic             finish;
  logic [IDX_W-1:0] scan_idx;

  logic             rd_used;
  logic [PID_W-1:0] rd_pid;
  logic [VPN_W-1:0] rd_vpn;

  logic [PID_W-1:0] pid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;

  logic             done_q;
  logic             fault_q;
  logic [PA_W-1:0]  pa_q;

  assign start = req_valid && !busy;
  assign hit   = busy && ipt_pkg::slot_hit(rd_used, rd_pid == pid_q, rd_vpn == vpn_q);

  ipt_table #(.FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_pid  (wr_pid),
    .wr_vpn  (wr_vpn),
    .wr_valid(wr_valid),
    .rd_idx  (scan_idx),
    .rd_used (rd_used),
    .rd_pid  (rd_pid),
    .rd_vpn  (rd_vpn)
  );

  ipt_scan #(.FRAMES(FRAMES)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .hit     (hit),
    .busy    (busy),
    .scan_idx(scan_idx),
    .last    (last),
    .finish  (finish)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pid_q <= '0;
      vpn_q <= '0;
      off_q <= '0;
    end else if (start) begin
      pid_q <= req_pid;
      vpn_q <= req_vpn;
      off_q <= req_off;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      done_q  <= finish;
      fault_q <= finish && !hit;
      if (finish) begin
        pa_q <= hit ? PA_W'(ipt_pkg::join_pa(32'(scan_idx), 32'(off_q), OFF_W)) : '0;
      end
    end
  end

  assign done   = done_q;
  assign fault  = fault_q;
  assign pa_out = pa_q;

endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int FRAMES = 32,
  parameter int IDX_W  = 5,
  parameter int PA_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             fault,
  input logic [PA_W-1:0]  pa_out,
  input logic             start,
  input logic [IDX_W-1:0] scan_idx
);

  assert_fault_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  assert_fault_zero_pa_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (pa_out == '0));

  assert_fault_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && scan_idx != IDX_W'(FRAMES - 1)) |=> !fault);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_walk_from_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && scan_idx == '0));

  assert_walk_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (!busy || scan_idx == $past(scan_idx) + IDX_W'(1)));

endmodule

bind ipt_lookup ipt_lookup_chk #(.FRAMES(FRAMES), .IDX_W(IDX_W), .PA_W(PA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .fault   (fault),
  .pa_out  (pa_out),
  .start   (start),
  .scan_idx(scan_idx)
);

// File: tb/tb_ipt_lookup.sv
`timescale 1ns/1ps
module tb_ipt_lookup;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_pid = '0;
  logic [10:0] req_vpn = '0;
  logic [10:0] req_off = '0;
  logic        busy, done, fault;
  logic [15:0] pa_out;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [7:0]  wr_pid = '0;
  logic [10:0] wr_vpn = '0;
  logic        wr_valid = 1'b0;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ipt_lookup dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pid(req_pid),
    .req_vpn(req_vpn), .req_off(req_off), .busy(busy), .done(done),
    .fault(fault), .pa_out(pa_out), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_pid(wr_pid), .wr_vpn(wr_vpn), .wr_valid(wr_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input int idx, input int pid, input int vpn, input bit v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_pid = 8'(pid); wr_vpn = 11'(vpn); wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // n counts negedges after acceptance until done is seen (k+1 for slot k).
  task automatic look(input int pid, input int vpn, input int off,
                      output logic [15:0] pa, output logic flt, output int n,
                      output logic done_next);
    @(negedge clk);
    req_valid = 1'b1; req_pid = 8'(pid); req_vpn = 11'(vpn); req_off = 11'(off);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 40);
    pa = pa_out;
    flt = fault;
    @(negedge clk);
    done_next = done;
  endtask

  function automatic logic [15:0] exp_pa(input int slot, input int off);
    return {5'(slot), 11'(off)};
  endfunction

  task automatic t_reset();
    logic [15:0] pa; logic flt, dn; int n;
    chk(!busy && !done && !fault, "R1", "flags after reset", {busy, done, fault}, 0);
    chk(pa_out == 0, "R1", "pa after reset", pa_out, 0);
    look(0, 0, 0, pa, flt, n, dn);
    chk(flt == 1'b1, "R1", "empty table fault", flt, 1);
    chk(n == 32, "R6", "miss latency", n, 32);
    chk(pa == 0, "R6", "pa on fault", pa, 0);
  endtask

  task automatic t_basic_hit();
    logic [15:0] pa; logic flt, dn; int n;
    put(5, 3, 'h123, 1'b1);
    look(3, 'h123, 'h7ff, pa, flt, n, dn);
    chk(!flt, "R2", "hit fault flag", flt, 0);
    chk(pa == exp_pa(5, 'h7ff), "R2", "hit pa slot5", pa, exp_pa(5, 'h7ff));
    chk(n == 6, "R5", "latency slot5", n, 6);
    chk(!dn, "R9", "done single pulse", dn, 0);
    chk(!busy, "R7", "idle after done", busy, 0);
  endtask

  task automatic t_edges();
    logic [15:0] pa; logic flt, dn; int n;
    put(0, 'hA0, 'h001, 1'b1);
    put(31, 'hA1, 'h3ff, 1'b1);
    look('hA0, 'h001, 'h2a, pa, flt, n, dn);
    chk(!flt && pa == exp_pa(0, 'h2a), "R2", "slot0 pa", pa, exp_pa(0, 'h2a));
    chk(n == 1, "R5", "latency slot0", n, 1);
    look('hA1, 'h3ff, 'h555, pa, flt, n, dn);
    chk(!flt && pa == exp_pa(31, 'h555), "R2", "slot31 pa", pa, exp_pa(31, 'h555));
    chk(n == 32, "R5", "latency slot31", n, 32);
  endtask

  task automatic t_partial();
    logic [15:0] pa; logic flt, dn; int n;
    look(3, 'h124, 0, pa, flt, n, dn);
    chk(flt == 1'b1, "R3", "tag-only agreement", flt, 1);
    look(4, 'h123, 0, pa, flt, n, dn);
    chk(flt == 1'b1, "R3", "page-only agreement", flt, 1);
  endtask

  task automatic t_unused();
    logic [15:0] pa; logic flt, dn; int n;
    put(9, 7, 'h55, 1'b0);
    look(7, 'h55, 1, pa, flt, n, dn);
    chk(flt == 1'b1, "R4", "unused slot match", flt, 1);
    put(5, 3, 'h123, 1'b0);
    look(3, 'h123, 1, pa, flt, n, dn);
    chk(flt == 1'b1, "R8", "cleared mapping", flt, 1);
  endtask

  task automatic t_dup();
    logic [15:0] pa; logic flt, dn; int n;
    put(25, 9, 'h2aa, 1'b1);
    put(12, 9, 'h2aa, 1'b1);
    look(9, 'h2aa, 'h10, pa, flt, n, dn);
    chk(!flt && pa == exp_pa(12, 'h10), "R5", "lowest slot wins", pa, exp_pa(12, 'h10));
    chk(n == 13, "R5", "latency duplicate", n, 13);
  endtask

  task automatic t_busy_ignore();
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_pid = 8'h66; req_vpn = 11'h066; req_off = 11'h1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7", "busy after accept", busy, 1);
    @(negedge clk);
    req_valid = 1'b1; req_pid = 8'd9; req_vpn = 11'h2aa; req_off = 11'h3;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7", "busy mid walk", busy, 1);
    n = 2;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(fault == 1'b1, "R7", "ignored request result", fault, 1);
    chk(n == 32, "R7", "ignored request latency", n, 32);
    @(negedge clk);
    chk(!done && !busy, "R7", "no second walk", {done, busy}, 0);
  endtask

  task automatic t_write_ahead();
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_pid = 8'h11; req_vpn = 11'h011; req_off = 11'h44;
    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b1; wr_idx = 5'd20; wr_pid = 8'h11; wr_vpn = 11'h011; wr_valid = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    n = 1;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(!fault && pa_out == exp_pa(20, 'h44), "R8", "write ahead of walk", pa_out, exp_pa(20, 'h44));
    chk(n == 21, "R8", "write ahead latency", n, 21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_hit();
    t_edges();
    t_partial();
    t_unused();
    t_dup();
    t_busy_ignore();
    t_write_ahead();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule